// File: doc/BRIEF.md
# Fabric-to-NoC Ingress Adapter

This block connects a wide, slow compute module in the programmable fabric to one input port of a narrow, fast on-chip network router. The module offers a word of up to 600 bits with a valid/ready handshake and states how many of those bits it uses. The adapter cuts the word into 150-bit flits, from one to four of them, and marks the first as head and the last as tail. The flits are written one per module clock into a dual-clock FIFO. The FIFO hands them to the router clock domain.

On the router side, a writer holds a credit count for the router's input buffer. It forwards a flit only while a credit is available. Each returned credit pulse lets one more flit go. When credits run out, flits collect in the FIFO. Once the FIFO has no room for the whole next word, the module-side ready falls, so backpressure reaches the module. The two clocks are unrelated, and each side has its own asynchronous active-low reset.

Top module: `fabric_noc_ingress`

## Requirements
- R1: The number of flits for a word follows from `m_bits`. A value of 0 to 150 gives 1 flit, 151 to 300 gives 2, 301 to 450 gives 3, and 451 or more gives 4.
- R2: The first flit of a word has `n_head` set and the last has `n_tail` set. A single-flit word has both set, and middle flits have neither.
- R3: Flit k of a word carries `m_data[150k+149:150k]`. Flits leave in ascending k, words leave in acceptance order, and no flit is lost or duplicated across the clock crossing.
- R4: After reset, `n_valid` is low and, with the FIFO empty, `m_ready` is high.
- R5: The credit count starts at the router buffer depth (default 10) and never exceeds it. While no credit returns, at most that many flits are sent. Each `n_credit` pulse allows exactly one more flit.
- R6: `m_ready` is low whenever the FIFO's free space is smaller than the flit count (R1) of the word currently presented on `m_bits`. It is high when the space is enough and no word is in progress.
- R7: After a multi-flit word is accepted, `m_ready` stays low until all its flits have been written. The flits enter the FIFO on consecutive module clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Module-side clock |
| mrst_n | input | 1 | Module-side asynchronous reset, active low |
| m_valid | input | 1 | Module word valid |
| m_ready | output | 1 | Adapter can take the presented word |
| m_data | input | 600 | Module word; flit k comes from bits 150k+149 down to 150k |
| m_bits | input | 10 | Count of used bits in `m_data`; selects the flit count |
| nclk | input | 1 | Router-side clock |
| nrst_n | input | 1 | Router-side asynchronous reset, active low |
| n_valid | output | 1 | Flit valid toward the router |
| n_flit | output | 150 | Flit payload |
| n_head | output | 1 | First flit of a word |
| n_tail | output | 1 | Last flit of a word |
| n_credit | input | 1 | One-cycle pulse returning one buffer credit |

## Verification
The bench covers the flit-count boundaries on both sides of each 150-bit step and at 0 and 600. A wrong comparison at a boundary would drop or add a flit and shift the head/tail marks. It starves the writer of credits until exactly the buffer depth of flits has left. A counter that was off by one would leak an extra flit or stall one early. With the FIFO partly full, the bench presents words of different sizes. This checks that ready depends on the flit count of each word: a fixed threshold would refuse small words that fit, or accept large ones that would split. It then returns credits and checks that every flit of the stalled words arrives intact and in order across the unrelated clocks.

// File: rtl/fabric_noc_ingress.sv
module fabric_noc_ingress #(
  parameter int FLIT_W     = 150,
  parameter int MAX_FLITS  = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int VC_DEPTH   = 10,
  localparam int WORD_W    = FLIT_W * MAX_FLITS,
  localparam int BITS_W    = $clog2(WORD_W + 1)
) (
  input  logic              mclk,
  input  logic              mrst_n,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [WORD_W-1:0] m_data,
  input  logic [BITS_W-1:0] m_bits,
  input  logic              nclk,
  input  logic              nrst_n,
  output logic              n_valid,
  output logic [FLIT_W-1:0] n_flit,
  output logic              n_head,
  output logic              n_tail,
  input  logic              n_credit
);
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int PW    = AW + 1;
  localparam int ENT_W = FLIT_W + 2;
  localparam int CNT_W = $clog2(MAX_FLITS + 1);
  localparam int IDX_W = $clog2(MAX_FLITS);
  localparam int CR_W  = $clog2(VC_DEPTH + 1);

  function automatic logic [CNT_W-1:0] flits_for(input logic [BITS_W-1:0] b);
    logic [CNT_W-1:0] n;
    n = CNT_W'(1);
    for (int k = 1; k < MAX_FLITS; k++)
      if (b > BITS_W'(k * FLIT_W)) n = CNT_W'(k + 1);
    return n;
  endfunction

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [ENT_W-1:0] mem [FIFO_DEPTH];

  // module-side serializer and write pointer
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word;
  logic [PW-1:0]     wbin, wgray, rg_s1, rg_s2;
  logic [PW-1:0]     used_w, free_w;
  logic [CNT_W-1:0]  in_cnt;
  logic              accept, wr_en, wr_head, wr_tail;
  logic [FLIT_W-1:0] wr_flit;
  logic [FLIT_W-1:0] slice [MAX_FLITS];

  for (genvar g = 0; g < MAX_FLITS; g++) begin : g_slice
    assign slice[g] = word[g*FLIT_W +: FLIT_W];
  end

  assign in_cnt  = flits_for(m_bits);
  assign used_w  = wbin - from_gray(rg_s2);
  assign free_w  = PW'(FIFO_DEPTH) - used_w;
  assign m_ready = !busy && (int'(free_w) >= int'(in_cnt));
  assign accept  = m_valid && m_ready;
  assign wr_en   = accept || busy;
  assign wr_head = accept;
  assign wr_flit = accept ? m_data[FLIT_W-1:0] : slice[idx];
  assign wr_tail = accept ? (in_cnt == CNT_W'(1))
                          : (CNT_W'(idx) + CNT_W'(1) == cnt);

  always_ff @(posedge mclk or negedge mrst_n) begin
    if (!mrst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      cnt   <= '0;
      word  <= '0;
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      if (accept) begin
        word <= m_data;
        cnt  <= in_cnt;
        idx  <= IDX_W'(1);
        busy <= (in_cnt != CNT_W'(1));
      end else if (busy) begin
        idx <= idx + IDX_W'(1);
        if (wr_tail) busy <= 1'b0;
      end
      if (wr_en) begin
        wbin  <= wbin + PW'(1);
        wgray <= to_gray(wbin + PW'(1));
      end
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end
  end

  always_ff @(posedge mclk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= {wr_head, wr_tail, wr_flit};
  end

  // router-side credit writer and read pointer
  logic [PW-1:0]    rbin, rgray, wg_s1, wg_s2;
  logic [CR_W-1:0]  credits;
  logic             empty, pop;
  logic [ENT_W-1:0] rd_ent;

  assign empty  = (rgray == wg_s2);
  assign pop    = !empty && (credits != '0);
  assign rd_ent = mem[rbin[AW-1:0]];

  always_ff @(posedge nclk or negedge nrst_n) begin
    if (!nrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      credits <= CR_W'(VC_DEPTH);
      n_valid <= 1'b0;
      n_flit  <= '0;
      n_head  <= 1'b0;
      n_tail  <= 1'b0;
    end else begin
      wg_s1   <= wgray;
      wg_s2   <= wg_s1;
      credits <= credits - CR_W'(pop) + CR_W'(n_credit);
      n_valid <= pop;
      if (pop) begin
        rbin   <= rbin + PW'(1);
        rgray  <= to_gray(rbin + PW'(1));
        n_head <= rd_ent[ENT_W-1];
        n_tail <= rd_ent[ENT_W-2];
        n_flit <= rd_ent[FLIT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fabric_noc_ingress_chk.sv
module fabric_noc_ingress_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int VC_DEPTH   = 10,
  localparam int PW        = $clog2(FIFO_DEPTH) + 1,
  localparam int CR_W      = $clog2(VC_DEPTH + 1)
) (
  input logic            mclk,
  input logic            mrst_n,
  input logic            busy,
  input logic            m_ready,
  input logic            wr_en,
  input logic            wr_head,
  input logic            wr_tail,
  input logic [PW-1:0]   used,
  input logic            nclk,
  input logic            nrst_n,
  input logic [CR_W-1:0] credits,
  input logic            n_valid
);
  AST_CREDIT_CAP: assert property (@(posedge nclk) disable iff (!nrst_n)
    int'(credits) <= VC_DEPTH); // R5
  AST_NO_SEND_DRY: assert property (@(posedge nclk) disable iff (!nrst_n)
    (credits == '0) |=> !n_valid); // R5
  AST_NO_OVERFLOW: assert property (@(posedge mclk) disable iff (!mrst_n)
    int'(used) <= FIFO_DEPTH); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge mclk) disable iff (!mrst_n)
    busy |-> !m_ready); // R7
  AST_BUSY_WRITES: assert property (@(posedge mclk) disable iff (!mrst_n)
    busy |-> wr_en); // R7
  AST_BODY_FOLLOWS: assert property (@(posedge mclk) disable iff (!mrst_n)
    (wr_en && !wr_head) |-> ($past(wr_en) && !$past(wr_tail))); // R2
endmodule

bind fabric_noc_ingress fabric_noc_ingress_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .VC_DEPTH(VC_DEPTH)
) u_chk (
  .mclk(mclk), .mrst_n(mrst_n), .busy(busy), .m_ready(m_ready),
  .wr_en(wr_en), .wr_head(wr_head), .wr_tail(wr_tail), .used(used_w),
  .nclk(nclk), .nrst_n(nrst_n), .credits(credits), .n_valid(n_valid)
);

// File: tb/fabric_noc_ingress_tb.sv
module fabric_noc_ingress_tb;
  localparam int FW = 150;
  localparam int WW = 600;
  localparam int NV = 9;
  localparam int VEC_BITS [NV] = '{0, 1, 150, 151, 300, 301, 450, 451, 600};
  localparam int VEC_N    [NV] = '{1, 1, 1,   2,   2,   3,   3,   4,   4};

  logic          mclk = 0, nclk = 0, mrst_n = 0, nrst_n = 0;
  logic          m_valid = 0, m_ready;
  logic [WW-1:0] m_data = '0;
  logic [9:0]    m_bits = '0;
  logic          n_valid, n_head, n_tail, n_credit = 0;
  logic [FW-1:0] n_flit;

  int checks = 0, errors = 0;
  int owed = 0;
  bit auto_ret = 1;
  logic [FW+1:0] rx_q [$];
  logic [FW+1:0] exp_q [$];

  always #5 mclk = ~mclk;
  always #2 nclk = ~nclk;

  fabric_noc_ingress u_dut (
    .mclk(mclk), .mrst_n(mrst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_bits(m_bits), .nclk(nclk), .nrst_n(nrst_n),
    .n_valid(n_valid), .n_flit(n_flit), .n_head(n_head), .n_tail(n_tail),
    .n_credit(n_credit)
  );

  always @(negedge nclk) begin
    if (!nrst_n) n_credit = 0;
    else begin
      if (n_valid) begin
        rx_q.push_back({n_head, n_tail, n_flit});
        if (auto_ret) owed++;
      end
      if (owed > 0) begin n_credit = 1; owed--; end
      else n_credit = 0;
    end
  end

  task automatic chk(bit ok, string tag, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk_word(int seed);
    logic [WW-1:0] w;
    for (int k = 0; k < 4; k++)
      w[k*FW +: FW] = {8'(seed + k), 134'(seed * 1000 + k * 7 + 1), 8'(k)};
    return w;
  endfunction

  task automatic send_word(int bits, int seed, int n);
    logic [WW-1:0] w;
    int tmo;
    w = mk_word(seed);
    for (int i = 0; i < n; i++)
      exp_q.push_back({(i == 0), (i == n - 1), w[i*FW +: FW]});
    @(negedge mclk);
    m_valid = 1; m_data = w; m_bits = 10'(bits);
    tmo = 0;
    while (!m_ready && tmo < 5000) begin @(negedge mclk); tmo++; end
    chk(tmo < 5000, "R6 word never accepted", 160'(tmo), 160'(0));
    @(posedge mclk);
    @(negedge mclk);
    if (n > 1) chk(m_ready == 0, "R7 ready low during word", 160'(m_ready), 160'(0));
    m_valid = 0;
  endtask

  task automatic compare_rx(string tag);
    int t;
    t = 0;
    while (rx_q.size() < exp_q.size() && t < 4000) begin @(negedge nclk); t++; end
    repeat (30) @(negedge nclk);
    chk(rx_q.size() == exp_q.size(), {tag, " flit count"},
        160'(rx_q.size()), 160'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], $sformatf("%s flit %0d head/tail/data", tag, i),
          160'(rx_q[i]), 160'(exp_q[i]));
    rx_q.delete();
    exp_q.delete();
  endtask

  task automatic probe_ready(int bits, bit expv, string tag);
    @(negedge mclk);
    m_bits = 10'(bits);
    #1;
    chk(m_ready == expv, tag, 160'(m_ready), 160'(expv));
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge mclk);
    mrst_n = 1; nrst_n = 1;
    repeat (3) @(negedge mclk);
    // R4 reset state
    chk(m_ready == 1, "R4 ready after reset", 160'(m_ready), 160'(1));
    chk(n_valid == 0, "R4 no flit after reset", 160'(n_valid), 160'(0));

    // R1 R2 R3: boundary vector table
    for (int i = 0; i < NV; i++) begin
      send_word(VEC_BITS[i], i + 1, VEC_N[i]);
      compare_rx($sformatf("R1 R2 R3 vector bits=%0d", VEC_BITS[i]));
    end

    // R3 back-to-back mixed words
    send_word(75, 40, 1);
    send_word(75, 41, 1);
    send_word(420, 42, 3);
    send_word(200, 43, 2);
    send_word(10, 44, 1);
    compare_rx("R3 back-to-back");

    // R5 credit starvation
    repeat (30) @(negedge nclk);
    auto_ret = 0;
    for (int i = 0; i < 4; i++) send_word(600, 60 + i, 4);
    repeat (200) @(negedge nclk);
    chk(rx_q.size() == 10, "R5 flits sent without credits", 160'(rx_q.size()), 160'(10));

    // R6 ready depends on the presented word's size (free = 2)
    probe_ready(600, 0, "R6 four-flit word refused");
    probe_ready(301, 0, "R6 three-flit word refused");
    probe_ready(300, 1, "R6 two-flit word fits");
    probe_ready(100, 1, "R6 one-flit word fits");

    // R5 each credit releases one flit
    @(posedge nclk); owed += 3;
    repeat (100) @(negedge nclk);
    chk(rx_q.size() == 13, "R5 three credits three flits", 160'(rx_q.size()), 160'(13));

    @(posedge nclk); owed += 10; auto_ret = 1;
    compare_rx("R3 R5 after starvation");

    // R4 reset again mid-idle
    @(negedge mclk); mrst_n = 0; nrst_n = 0;
    repeat (3) @(negedge mclk);
    mrst_n = 1; nrst_n = 1; owed = 0;
    repeat (3) @(negedge mclk);
    m_bits = 10'd600; #1;
    chk(m_ready == 1, "R4 ready after second reset", 160'(m_ready), 160'(1));
    send_word(451, 90, 4);
    compare_rx("R1 R4 word after second reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule